// File: doc/BRIEF.md
# Dual-Slot Instruction Pair Dispatcher

This block takes one 64-bit fetched bundle at a time and hands its sub-instructions to a memory-side slot and an integer-side slot. Two format bits in the bundle pick one of four modes: a single long instruction, two short instructions issued together, or two short instructions run one after the other with either half first. The execution units sit outside the block. Each slot has a valid/ready issue handshake. A unit returns its branch flag, its branch target and its kill-next request in the same cycle its issue is accepted.

The dispatcher merges the slot results into one next-PC decision. It reports that decision with a one-cycle done pulse. For a sequential pair, the second sub-instruction is dropped when the first one branches or asks to kill the next. A parallel pair in which both slots branch cannot be resolved, so it raises an abort flag instead of a next PC.

Top module: `pair_dispatch`

## Requirements
- R1: Under reset and in the first cycle after it, `bundle_ready_o` is 1, `iss_valid_o` is 0 and `done_o` is 0.
- R2: The mode is {bundle bit 63, bundle bit 31}: 0 parallel, 1 upper-then-lower, 2 lower-then-upper, 3 long. While a bundle is in flight, `iss_mem_insn_o` carries bundle bits 63:32 and `iss_int_insn_o` carries bits 31:0.
- R3: A parallel bundle raises both strobes (`iss_valid_o` = 2'b11) in the cycle after acceptance. It is issued in the first cycle in which both ready inputs are high.
- R4: When a parallel bundle finishes, exactly one branching slot gives that slot's target. No branch gives `done_branch_o` = 0. Two branches give `abort_o` = 1 with `done_branch_o` = 0.
- R5: An upper-then-lower bundle first raises only the memory strobe (2'b01) with `iss_any_o` = 0. If it continues, it then raises only the integer strobe (2'b10) with `iss_any_o` = 1.
- R6: A lower-then-upper bundle first raises only the integer strobe (2'b10). If it continues, it then raises only the memory strobe (2'b01) with `iss_any_o` = 1.
- R7: In a sequential bundle, a branch or a kill request from the first sub-instruction ends the bundle without issuing the second. The next PC is the first's target if it branched, and no branch otherwise.
- R8: When the second sub-instruction of a sequential bundle issues, its branch flag and target alone decide the next PC.
- R9: A long bundle raises both strobes with `iss_long_o` = 1. The next PC comes only from the memory-slot result, and the integer-slot result has no effect.
- R10: `done_o` is a single-cycle pulse in the cycle after the final issue. `bundle_ready_o` is high exactly when no bundle is in flight, and no strobe is raised while it is high.
- R11: A raised strobe whose ready is low keeps the same strobe pattern in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bundle_valid_i | input | 1 | Bundle offered |
| bundle_ready_o | output | 1 | Dispatcher idle, bundle taken when valid |
| bundle_i | input | 2*HALF_W | Fetched bundle |
| iss_valid_o | output | 2 | Issue strobes, bit 0 memory slot, bit 1 integer slot |
| iss_ready_i | input | 2 | Unit ready, same bit order |
| iss_any_o | output | 1 | Strobed sub-instruction may run on either unit |
| iss_long_o | output | 1 | Both halves form one long instruction |
| iss_mem_insn_o | output | HALF_W | Upper half of the bundle |
| iss_int_insn_o | output | HALF_W | Lower half of the bundle |
| res_branch_i | input | 2 | Branch taken per slot, valid on issue |
| res_kill_i | input | 2 | Kill-next request per slot, valid on issue |
| res_mem_target_i | input | ADDR_W | Memory-slot branch target |
| res_int_target_i | input | ADDR_W | Integer-slot branch target |
| done_o | output | 1 | Bundle finished |
| done_branch_o | output | 1 | Next PC is a taken branch |
| done_target_o | output | ADDR_W | Branch target, zero when no branch |
| abort_o | output | 1 | Conflicting parallel branches |

## Verification
The assertions assume that units sample result inputs only in a cycle where their strobe and ready are both high. They also assume that ready may fall and rise freely, so a held strobe must tolerate any ready pattern. The stimulus drives random ready, branch and kill values on every cycle, including cycles with no strobe, so the block must ignore results outside a handshake. Bundles are built with chosen format bits and random payloads. Directed sequences add parallel stalls on one unit and conflicting branches.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    FMT_PAR  = 2'd0,
    FMT_LR   = 2'd1,
    FMT_RL   = 2'd2,
    FMT_LONG = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;

  localparam int SLOT_MEM = 0;
  localparam int SLOT_INT = 1;
  localparam int NUM_SLOTS = 2;
endpackage

// File: rtl/pd_format.sv
module pd_format
  import pd_pkg::*;
#(
  parameter int HALF_W = 32,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic [WORD_W-1:0] word_i,
  output fmt_e              fmt_o,
  output logic [HALF_W-1:0] upper_o,
  output logic [HALF_W-1:0] lower_o
);
  assign fmt_o   = fmt_e'({word_i[WORD_W-1], word_i[HALF_W-1]});
  assign upper_o = word_i[WORD_W-1:HALF_W];
  assign lower_o = word_i[HALF_W-1:0];
endmodule

// File: rtl/pd_issue_ctl.sv
module pd_issue_ctl
  import pd_pkg::*;
(
  input  phase_e               phase_i,
  input  fmt_e                 fmt_i,
  input  logic [NUM_SLOTS-1:0] ready_i,
  output logic [NUM_SLOTS-1:0] valid_o,
  output logic                 any_o,
  output logic                 long_o,
  output logic                 fire_o
);
  always_comb begin
    valid_o = '0;
    any_o   = 1'b0;
    long_o  = 1'b0;
    unique case (phase_i)
      PH_FIRST: begin
        unique case (fmt_i)
          FMT_PAR:  valid_o = 2'b11;
          FMT_LR:   valid_o[SLOT_MEM] = 1'b1;
          FMT_RL:   valid_o[SLOT_INT] = 1'b1;
          FMT_LONG: begin
            valid_o = 2'b11;
            long_o  = 1'b1;
          end
          default:  valid_o = '0;
        endcase
      end
      PH_SECOND: begin
        any_o = 1'b1;
        if (fmt_i == FMT_RL) valid_o[SLOT_MEM] = 1'b1;
        else                 valid_o[SLOT_INT] = 1'b1;
      end
      default: valid_o = '0;
    endcase
  end

  // all strobed slots must be accepted together
  assign fire_o = (|valid_o) && ((valid_o & ~ready_i) == '0);
endmodule

// File: rtl/pd_merge.sv
module pd_merge
  import pd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  fmt_e                 fmt_i,
  input  logic                 second_i,
  input  logic [NUM_SLOTS-1:0] branch_i,
  input  logic [NUM_SLOTS-1:0] kill_i,
  input  logic [ADDR_W-1:0]    mem_target_i,
  input  logic [ADDR_W-1:0]    int_target_i,
  output logic                 branch_o,
  output logic [ADDR_W-1:0]    target_o,
  output logic                 abort_o,
  output logic                 cont_o
);
  logic seq_slot;

  // first sub-instruction of a right-first pair runs on the integer slot
  assign seq_slot = (fmt_i == FMT_RL) ^ second_i;

  always_comb begin
    branch_o = 1'b0;
    target_o = mem_target_i;
    abort_o  = 1'b0;
    cont_o   = 1'b0;
    unique case (fmt_i)
      FMT_PAR: begin
        branch_o = branch_i[SLOT_MEM] ^ branch_i[SLOT_INT];
        target_o = branch_i[SLOT_MEM] ? mem_target_i : int_target_i;
        abort_o  = &branch_i;
      end
      FMT_LONG: begin
        branch_o = branch_i[SLOT_MEM];
        target_o = mem_target_i;
      end
      default: begin
        branch_o = branch_i[seq_slot];
        target_o = seq_slot ? int_target_i : mem_target_i;
        cont_o   = !second_i && !branch_i[seq_slot] && !kill_i[seq_slot];
      end
    endcase
  end
endmodule

// File: rtl/pair_dispatch.sv
module pair_dispatch
  import pd_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int ADDR_W = 32,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bundle_valid_i,
  output logic              bundle_ready_o,
  input  logic [WORD_W-1:0] bundle_i,
  output logic [1:0]        iss_valid_o,
  input  logic [1:0]        iss_ready_i,
  output logic              iss_any_o,
  output logic              iss_long_o,
  output logic [HALF_W-1:0] iss_mem_insn_o,
  output logic [HALF_W-1:0] iss_int_insn_o,
  input  logic [1:0]        res_branch_i,
  input  logic [1:0]        res_kill_i,
  input  logic [ADDR_W-1:0] res_mem_target_i,
  input  logic [ADDR_W-1:0] res_int_target_i,
  output logic              done_o,
  output logic              done_branch_o,
  output logic [ADDR_W-1:0] done_target_o,
  output logic              abort_o
);
  phase_e              phase_q;
  logic [WORD_W-1:0]   bundle_q;
  fmt_e                fmt;
  logic                fire;
  logic                m_branch, m_abort, m_cont;
  logic [ADDR_W-1:0]   m_target;
  logic                done_q, branch_q, abort_q;
  logic [ADDR_W-1:0]   target_q;

  pd_format #(.HALF_W(HALF_W)) u_format (
    .word_i  (bundle_q),
    .fmt_o   (fmt),
    .upper_o (iss_mem_insn_o),
    .lower_o (iss_int_insn_o)
  );

  pd_issue_ctl u_issue (
    .phase_i (phase_q),
    .fmt_i   (fmt),
    .ready_i (iss_ready_i),
    .valid_o (iss_valid_o),
    .any_o   (iss_any_o),
    .long_o  (iss_long_o),
    .fire_o  (fire)
  );

  pd_merge #(.ADDR_W(ADDR_W)) u_merge (
    .fmt_i        (fmt),
    .second_i     (phase_q == PH_SECOND),
    .branch_i     (res_branch_i),
    .kill_i       (res_kill_i),
    .mem_target_i (res_mem_target_i),
    .int_target_i (res_int_target_i),
    .branch_o     (m_branch),
    .target_o     (m_target),
    .abort_o      (m_abort),
    .cont_o       (m_cont)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      bundle_q <= '0;
      done_q   <= 1'b0;
      branch_q <= 1'b0;
      abort_q  <= 1'b0;
      target_q <= '0;
    end else begin
      done_q   <= 1'b0;
      branch_q <= 1'b0;
      abort_q  <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (bundle_valid_i) begin
            bundle_q <= bundle_i;
            phase_q  <= PH_FIRST;
          end
        end
        PH_FIRST, PH_SECOND: begin
          if (fire) begin
            if (m_cont) begin
              phase_q <= PH_SECOND;
            end else begin
              phase_q  <= PH_IDLE;
              done_q   <= 1'b1;
              branch_q <= m_branch;
              abort_q  <= m_abort;
              target_q <= m_branch ? m_target : '0;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign bundle_ready_o = (phase_q == PH_IDLE);
  assign done_o         = done_q;
  assign done_branch_o  = branch_q;
  assign done_target_o  = target_q;
  assign abort_o        = abort_q;
endmodule

// File: rtl/pd_checker.sv
module pd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bundle_valid_i,
  input logic       bundle_ready_o,
  input logic [1:0] iss_valid_o,
  input logic [1:0] iss_ready_i,
  input logic       iss_any_o,
  input logic       iss_long_o,
  input logic       done_o,
  input logic       done_branch_o,
  input logic       abort_o
);
  AST_IDLE_NO_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bundle_ready_o |-> iss_valid_o == 2'b00); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> bundle_ready_o); // R10
  AST_ACCEPT_ISSUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bundle_valid_i && bundle_ready_o |=> iss_valid_o != 2'b00); // R3
  AST_HOLD_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o & ~iss_ready_i) != 2'b00 |=>
      $stable(iss_valid_o) && $stable(iss_any_o) && $stable(iss_long_o)); // R11
  AST_ABORT_NO_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> done_o && !done_branch_o); // R4
  AST_ANY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_any_o |-> $onehot(iss_valid_o) && !iss_long_o); // R5
  AST_LONG_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_long_o |-> iss_valid_o == 2'b11); // R9
endmodule

bind pair_dispatch pd_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .bundle_valid_i (bundle_valid_i),
  .bundle_ready_o (bundle_ready_o),
  .iss_valid_o    (iss_valid_o),
  .iss_ready_i    (iss_ready_i),
  .iss_any_o      (iss_any_o),
  .iss_long_o     (iss_long_o),
  .done_o         (done_o),
  .done_branch_o  (done_branch_o),
  .abort_o        (abort_o)
);

// File: tb/pair_dispatch_tb.sv
`timescale 1ns/1ps
module pair_dispatch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bv = 1'b0;
  logic [63:0] bundle = '0;
  logic [1:0]  rdy = 2'b00;
  logic [1:0]  rbr = 2'b00;
  logic [1:0]  rkill = 2'b00;
  logic [31:0] tm = '0;
  logic [31:0] ti = '0;

  logic        b_ready, any_o, long_o, done, done_br, abort;
  logic [1:0]  vld;
  logic [31:0] mem_insn, int_insn, done_tgt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pair_dispatch u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bundle_valid_i(bv), .bundle_ready_o(b_ready), .bundle_i(bundle),
    .iss_valid_o(vld), .iss_ready_i(rdy), .iss_any_o(any_o), .iss_long_o(long_o),
    .iss_mem_insn_o(mem_insn), .iss_int_insn_o(int_insn),
    .res_branch_i(rbr), .res_kill_i(rkill),
    .res_mem_target_i(tm), .res_int_target_i(ti),
    .done_o(done), .done_branch_o(done_br), .done_target_o(done_tgt), .abort_o(abort)
  );

  // behavioural reference
  int          m_phase = 0;
  int          m_fmt = 0;
  logic [63:0] m_bundle = '0;
  bit          m_done = 0, m_br = 0, m_abort = 0, m_held = 0;
  logic [31:0] m_tgt = '0;
  string       m_tag = "R10";

  function automatic logic [1:0] exp_valid();
    if (m_phase == 1) begin
      if (m_fmt == 1) return 2'b01;
      if (m_fmt == 2) return 2'b10;
      return 2'b11;
    end
    if (m_phase == 2) return (m_fmt == 1) ? 2'b10 : 2'b01;
    return 2'b00;
  endfunction

  function automatic string fmt_tag();
    if (m_fmt == 0) return "R3";
    if (m_fmt == 1) return "R5";
    if (m_fmt == 2) return "R6";
    return "R9";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_done = 0; m_br = 0; m_abort = 0; m_held = 0; m_tgt = '0;
    end else begin
      logic [1:0] need;
      need = exp_valid();
      m_done = 0; m_br = 0; m_abort = 0; m_held = 0;
      if (m_phase == 0) begin
        if (bv) begin
          m_bundle = bundle;
          m_fmt = {30'd0, bundle[63], bundle[31]};
          m_phase = 1;
        end
      end else if ((need & ~rdy) != 2'b00) begin
        m_held = 1;
      end else if (m_fmt == 0) begin
        m_done = 1; m_phase = 0; m_tag = "R4";
        if (rbr == 2'b11) m_abort = 1;
        else if (rbr == 2'b01) begin m_br = 1; m_tgt = tm; end
        else if (rbr == 2'b10) begin m_br = 1; m_tgt = ti; end
        if (!m_br) m_tgt = '0;
      end else if (m_fmt == 3) begin
        m_done = 1; m_phase = 0; m_tag = "R9";
        m_br = rbr[0]; m_tgt = rbr[0] ? tm : '0;
      end else begin
        int s;
        s = (m_fmt == 2) ? 1 : 0;
        if (m_phase == 2) s = 1 - s;
        if (m_phase == 1 && !rbr[s] && !rkill[s]) begin
          m_phase = 2;
        end else begin
          m_tag = (m_phase == 1) ? "R7" : "R8";
          m_done = 1; m_phase = 0;
          m_br = rbr[s];
          m_tgt = rbr[s] ? (s == 1 ? ti : tm) : '0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [1:0] ev;
    ev = exp_valid();
    check(b_ready == (m_phase == 0), "R10", 64'(b_ready), 64'(m_phase == 0));
    check(vld == ev, m_held ? "R11" : fmt_tag(), 64'(vld), 64'(ev));
    check(any_o == (m_phase == 2), (m_fmt == 2) ? "R6" : "R5", 64'(any_o), 64'(m_phase == 2));
    check(long_o == (m_phase == 1 && m_fmt == 3), "R9", 64'(long_o), 64'(m_phase == 1 && m_fmt == 3));
    if (ev != 2'b00) begin
      check(mem_insn == m_bundle[63:32], "R2", 64'(mem_insn), 64'(m_bundle[63:32]));
      check(int_insn == m_bundle[31:0], "R2", 64'(int_insn), 64'(m_bundle[31:0]));
    end
    check(done == m_done, "R10", 64'(done), 64'(m_done));
    if (m_done) begin
      check(done_br == m_br, m_tag, 64'(done_br), 64'(m_br));
      check(abort == m_abort, m_tag, 64'(abort), 64'(m_abort));
      check(done_tgt == m_tgt, m_tag, 64'(done_tgt), 64'(m_tgt));
    end
  endtask

  task automatic step(input bit v, input logic [1:0] f, input logic [1:0] r,
                      input logic [1:0] b, input logic [1:0] k);
    @(negedge clk);
    compare();
    bv = v;
    bundle = {$urandom, $urandom};
    bundle[63] = f[1];
    bundle[31] = f[0];
    rdy = r; rbr = b; rkill = k;
    tm = $urandom; ti = $urandom;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check(b_ready == 1'b1, "R1", 64'(b_ready), 64'd1);
    check(vld == 2'b00, "R1", 64'(vld), 64'd0);
    check(done == 1'b0, "R1", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(b_ready == 1'b1 && vld == 2'b00 && done == 1'b0, "R1",
          64'({b_ready, vld, done}), 64'b1000);
    // R3/R11: parallel held while integer unit stalls, then both branch (R4 abort)
    step(1, 2'd0, 2'b00, 2'b00, 2'b00);
    step(0, 2'd0, 2'b01, 2'b11, 2'b00);
    step(0, 2'd0, 2'b01, 2'b11, 2'b00);
    step(0, 2'd0, 2'b11, 2'b11, 2'b00);
    step(0, 2'd0, 2'b00, 2'b00, 2'b00);
    // R4 single branch from integer slot
    step(1, 2'd0, 2'b11, 2'b00, 2'b00);
    step(0, 2'd0, 2'b11, 2'b10, 2'b00);
    step(0, 2'd0, 2'b00, 2'b00, 2'b00);
    // R7 kill from first of upper-then-lower
    step(1, 2'd1, 2'b11, 2'b00, 2'b00);
    step(0, 2'd0, 2'b11, 2'b00, 2'b01);
    step(0, 2'd0, 2'b00, 2'b00, 2'b00);
    // R6/R8 lower-then-upper, second branches
    step(1, 2'd2, 2'b11, 2'b00, 2'b00);
    step(0, 2'd0, 2'b11, 2'b00, 2'b00);
    step(0, 2'd0, 2'b11, 2'b01, 2'b00);
    step(0, 2'd0, 2'b00, 2'b00, 2'b00);
    // R9 long, integer-slot branch ignored
    step(1, 2'd3, 2'b11, 2'b00, 2'b00);
    step(0, 2'd0, 2'b11, 2'b10, 2'b10);
    step(0, 2'd0, 2'b00, 2'b00, 2'b00);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] r, b, k;
      r[0] = ($urandom % 4) != 0;
      r[1] = ($urandom % 4) != 0;
      b[0] = ($urandom % 10) < 3;
      b[1] = ($urandom % 10) < 3;
      k[0] = ($urandom % 5) == 0;
      k[1] = ($urandom % 5) == 0;
      step(($urandom % 10) < 7, 2'($urandom), r, b, k);
    end
    step(0, 2'd0, 2'b11, 2'b00, 2'b00);
    summary();
  end
endmodule